// File: doc/BRIEF.md
# Register-Fed Transmit Packet FIFO

This block takes single 32-bit register writes from a processor and turns them into packets on an AXI4-Stream master port. Software first reads the free-space register to learn how many words fit. It then writes the payload one word at a time to the data register. Finally it writes the packet size in bytes to the length register. The length write commits every word written since the previous commit as one packet.

Committed packets leave the buffer in write order. Each word is driven while TREADY is high, and TLAST is set on the final word of each packet. Words that have not yet been committed are never streamed. Slots are handed back to the free-space count as the downstream side accepts words. The reported free space tops out four words below the storage depth.

A status register collects four sticky events:
- a keyed flush has completed;
- the committed length did not match the words written;
- a packet has fully left;
- a word was written with no room.

Software clears these events by writing ones. A single interrupt line is high while any of them is set.

Top module: `tx_pkt_fifo`

## Requirements
- R1: After hardware reset, m_tvalid and tx_irq are low, status (offset 0x00) reads 0, free space (offset 0x0C) reads DEPTH-4 (60 by default) and length (offset 0x14) reads 0.
- R2: Each data write (offset 0x10) that is accepted lowers free space by one, and each word accepted downstream raises it by one. Free space never exceeds DEPTH-4.
- R3: No word is streamed before a length write (offset 0x14) commits it. Committed words leave in write order, with m_tlast high only on the last word written before that commit.
- R4: While m_tvalid is high and m_tready is low, m_tvalid, m_tdata and m_tlast hold their values.
- R5: Reading offset 0x14 returns the byte count of the most recent length write.
- R6: A length write whose byte count differs from 4 times the words written since the previous commit sets status bit 25. The words actually written are still sent as one packet, and a commit with no pending words sends nothing.
- R7: A data write while free space is 0 drops the word and sets status bit 28.
- R8: Status bit 27 is set in the cycle after the handshake of a packet's final word.
- R9: Writing exactly 0x000000A5 to offset 0x08 empties the buffer, discards any uncommitted words, clears the length register and sets status bit 24. Any other value written there has no effect.
- R10: Writing to offset 0x00 clears each status bit whose write-data bit is 1. tx_irq is high exactly while any status bit is set.
- R11: Several committed packets queue up and are emitted one after another, each with its own m_tlast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Access is a write when high |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| m_tvalid | output | 1 | Stream word valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 32 | Stream word |
| m_tlast | output | 1 | Final word of a packet |
| tx_irq | output | 1 | Any status event pending |

## Verification
Corrupted pointer state shows up at the free-space register on the very next read. It also shows up on the stream port, as a word out of order or a word missing in the first cycle that word is presented. A lost or misplaced end-of-packet flag shows as m_tlast on the wrong beat, measured against the word count the bench committed. Event bits are registered, so a missed or spurious event is visible on tx_irq and in the status read one cycle after its cause. A flush that leaves stale state is exposed by the next single-word packet, which must come out alone.

// File: rtl/txf_pkg.sv
package txf_pkg;
  localparam int unsigned WORD_W = 32;

  // register byte offsets
  localparam logic [31:0] OFS_STATUS  = 32'h00;
  localparam logic [31:0] OFS_FLUSH   = 32'h08;
  localparam logic [31:0] OFS_FREE    = 32'h0C;
  localparam logic [31:0] OFS_DATA    = 32'h10;
  localparam logic [31:0] OFS_LENGTH  = 32'h14;

  localparam logic [31:0] FLUSH_KEY   = 32'h0000_00A5;

  // status bit positions
  localparam int unsigned BIT_FLUSHED  = 24;
  localparam int unsigned BIT_LEN_ERR  = 25;
  localparam int unsigned BIT_SENT     = 27;
  localparam int unsigned BIT_OVERRUN  = 28;

  localparam logic [31:0] STATUS_MASK =
    (32'h1 << BIT_FLUSHED) | (32'h1 << BIT_LEN_ERR) |
    (32'h1 << BIT_SENT)    | (32'h1 << BIT_OVERRUN);
endpackage

// File: rtl/txf_decode.sv
module txf_decode #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              sts_clr,
  output logic              flush,
  output logic              data_we,
  output logic              len_we
);
  import txf_pkg::*;

  logic        wr_acc;
  logic [31:0] ofs;

  assign wr_acc = reg_valid & reg_write;
  assign ofs    = 32'(reg_addr);

  always_comb begin
    sts_clr = wr_acc && (ofs == OFS_STATUS);
    flush   = wr_acc && (ofs == OFS_FLUSH) && (reg_wdata == FLUSH_KEY);
    data_we = wr_acc && (ofs == OFS_DATA);
    len_we  = wr_acc && (ofs == OFS_LENGTH);
  end
endmodule

// File: rtl/txf_buffer.sv
module txf_buffer #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned RESERVE = 4,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned PW     = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          data_we,
  input  logic          len_we,
  input  logic [31:0]   wdata,
  input  logic          m_tready,
  output logic          m_tvalid,
  output logic [31:0]   m_tdata,
  output logic          m_tlast,
  output logic [PW-1:0] free_words,
  output logic          ev_overrun,
  output logic          ev_len_err,
  output logic          ev_sent
);
  localparam int unsigned CAP = DEPTH - RESERVE;

  logic [PW-1:0]    wr_q, wr_d, cmt_q, cmt_d, rd_q, rd_d;
  logic             ptr_en;
  logic [31:0]      mem_q [DEPTH];
  logic [DEPTH-1:0] last_q, last_d;
  logic             last_en;

  logic [PW-1:0]    occ, pend;
  logic [AW-1:0]    wr_idx, tail_idx, rd_idx;
  logic             at_cap, accept, commit, fire;

  assign occ      = wr_q - rd_q;
  assign pend     = wr_q - cmt_q;
  assign wr_idx   = wr_q[AW-1:0];
  assign tail_idx = wr_q[AW-1:0] - AW'(1);
  assign rd_idx   = rd_q[AW-1:0];
  assign at_cap   = (occ == PW'(CAP));

  assign free_words = PW'(CAP) - occ;

  assign accept     = data_we & ~at_cap & ~flush;
  assign ev_overrun = data_we & at_cap;
  assign ev_len_err = len_we & (wdata != (32'(pend) << 2));
  assign commit     = len_we & (pend != '0) & ~flush;

  assign m_tvalid = (rd_q != cmt_q);
  assign m_tdata  = mem_q[rd_idx];
  assign m_tlast  = m_tvalid & last_q[rd_idx];
  assign fire     = m_tvalid & m_tready;
  assign ev_sent  = fire & m_tlast & ~flush;

  // pointer next state
  always_comb begin
    wr_d  = wr_q + PW'(accept);
    rd_d  = rd_q + PW'(fire);
    cmt_d = commit ? wr_q : cmt_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cmt_d = '0;
    end
  end

  assign ptr_en = flush | accept | fire | commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cmt_q <= '0;
    end else if (ptr_en) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cmt_q <= cmt_d;
    end
  end

  // end-of-packet flags, one per slot
  always_comb begin
    last_d = last_q;
    if (accept) last_d[wr_idx]   = 1'b0;
    if (commit) last_d[tail_idx] = 1'b1;
  end

  assign last_en = accept | commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else if (last_en) begin
      last_q <= last_d;
    end
  end

  // payload storage, no reset
  always_ff @(posedge clk) begin
    if (accept) begin
      mem_q[wr_idx] <= wdata;
    end
  end
endmodule

// File: rtl/txf_csr.sv
module txf_csr #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned PW     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              sts_clr,
  input  logic              flush,
  input  logic              len_we,
  input  logic [PW-1:0]     free_words,
  input  logic              ev_overrun,
  input  logic              ev_len_err,
  input  logic              ev_sent,
  output logic [31:0]       reg_rdata,
  output logic              tx_irq
);
  import txf_pkg::*;

  logic [31:0] sts_q, sts_d;
  logic        sts_en;
  logic [31:0] len_q, len_d;
  logic        len_en;
  logic [31:0] ofs;

  always_comb begin
    sts_d = sts_q;
    if (sts_clr)    sts_d = sts_q & ~(reg_wdata & STATUS_MASK);
    if (flush)      sts_d[BIT_FLUSHED] = 1'b1;
    if (ev_len_err) sts_d[BIT_LEN_ERR] = 1'b1;
    if (ev_sent)    sts_d[BIT_SENT]    = 1'b1;
    if (ev_overrun) sts_d[BIT_OVERRUN] = 1'b1;
  end

  assign sts_en = sts_clr | flush | ev_len_err | ev_sent | ev_overrun;

  always_comb begin
    len_d = len_q;
    if (flush)       len_d = '0;
    else if (len_we) len_d = reg_wdata;
  end

  assign len_en = flush | len_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (sts_en) begin
      sts_q <= sts_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_en) begin
      len_q <= len_d;
    end
  end

  assign ofs    = 32'(reg_addr);
  assign tx_irq = |sts_q;

  always_comb begin
    reg_rdata = '0;
    if (ofs == OFS_STATUS)      reg_rdata = sts_q;
    else if (ofs == OFS_FREE)   reg_rdata = 32'(free_words);
    else if (ofs == OFS_LENGTH) reg_rdata = len_q;
  end
endmodule

// File: rtl/tx_pkt_fifo.sv
module tx_pkt_fifo #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned RESERVE = 4,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic [31:0]       m_tdata,
  output logic              m_tlast,
  output logic              tx_irq
);
  localparam int unsigned PW = $clog2(DEPTH) + 1;

  logic          sts_clr, flush, data_we, len_we;
  logic [PW-1:0] vac_w;
  logic          ev_overrun, ev_len_err, ev_sent;

  txf_decode #(.ADDR_W(ADDR_W)) u_decode (
    .reg_valid (reg_valid),
    .reg_write (reg_write),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sts_clr   (sts_clr),
    .flush     (flush),
    .data_we   (data_we),
    .len_we    (len_we)
  );

  txf_buffer #(.DEPTH(DEPTH), .RESERVE(RESERVE)) u_buffer (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .data_we    (data_we),
    .len_we     (len_we),
    .wdata      (reg_wdata),
    .m_tready   (m_tready),
    .m_tvalid   (m_tvalid),
    .m_tdata    (m_tdata),
    .m_tlast    (m_tlast),
    .free_words (vac_w),
    .ev_overrun (ev_overrun),
    .ev_len_err (ev_len_err),
    .ev_sent    (ev_sent)
  );

  txf_csr #(.ADDR_W(ADDR_W), .PW(PW)) u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .sts_clr    (sts_clr),
    .flush      (flush),
    .len_we     (len_we),
    .free_words (vac_w),
    .ev_overrun (ev_overrun),
    .ev_len_err (ev_len_err),
    .ev_sent    (ev_sent),
    .reg_rdata  (reg_rdata),
    .tx_irq     (tx_irq)
  );
endmodule

// File: rtl/txf_checks.sv
module txf_checks #(
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned RESERVE = 4,
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned PW      = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_valid,
  input logic              reg_write,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic [31:0]       m_tdata,
  input logic              m_tlast,
  input logic              tx_irq,
  input logic [PW-1:0]     vacancy
);
  import txf_pkg::*;

  localparam int unsigned CAP = DEPTH - RESERVE;

  logic key_wr, data_wr;
  assign key_wr  = reg_valid && reg_write && (32'(reg_addr) == OFS_FLUSH) && (reg_wdata == FLUSH_KEY);
  assign data_wr = reg_valid && reg_write && (32'(reg_addr) == OFS_DATA);

  // R2: free space bounded by depth minus reserve
  a_r2_vac_bound: assert property (@(posedge clk) disable iff (!rst_n)
    vacancy <= PW'(CAP));

  // R4: stalled beat is held
  a_r4_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready && !key_wr) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  // R7: write with no room raises the interrupt
  a_r7_overrun_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && vacancy == '0) |=> tx_irq);

  // R8: final beat handshake raises the interrupt
  a_r8_sent_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && m_tlast && !key_wr) |=> tx_irq);

  // R9: keyed flush empties the buffer
  a_r9_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> (vacancy == PW'(CAP) && !m_tvalid && tx_irq));
endmodule

bind tx_pkt_fifo txf_checks #(
  .DEPTH(DEPTH), .RESERVE(RESERVE), .ADDR_W(ADDR_W), .PW(PW)
) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_valid (reg_valid),
  .reg_write (reg_write),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .m_tvalid  (m_tvalid),
  .m_tready  (m_tready),
  .m_tdata   (m_tdata),
  .m_tlast   (m_tlast),
  .tx_irq    (tx_irq),
  .vacancy   (vac_w)
);

// File: tb/test_tx_pkt_fifo.sv
module test_tx_pkt_fifo;
  localparam int unsigned DEPTH = 64;
  localparam int unsigned CAP   = DEPTH - 4;

  localparam logic [5:0] A_STS = 6'h00, A_FLUSH = 6'h08, A_FREE = 6'h0C, A_DATA = 6'h10, A_LEN = 6'h14;
  localparam logic [31:0] S_FLUSHED = 32'h0100_0000, S_LEN_ERR = 32'h0200_0000,
                          S_SENT = 32'h0800_0000, S_OVR = 32'h1000_0000;

  typedef struct packed {
    logic [7:0] words;
    logic [7:0] bytes;
    logic       mism;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{8'd1, 8'd4,  1'b0},
    '{8'd3, 8'd12, 1'b0},
    '{8'd4, 8'd8,  1'b1},
    '{8'd2, 8'd20, 1'b1},
    '{8'd6, 8'd24, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_valid, reg_write;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        m_tvalid, m_tready, m_tlast, tx_irq;
  logic [31:0] m_tdata;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  tx_pkt_fifo #(.DEPTH(DEPTH), .RESERVE(4), .ADDR_W(6)) i_tx_pkt_fifo (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tlast(m_tlast), .tx_irq(tx_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic reg_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic put_words(input int n, input logic [31:0] base);
    for (int k = 0; k < n; k++) reg_wr(A_DATA, base + 32'(k));
  endtask

  task automatic drain(input int n, input logic [31:0] base, input string req);
    int got = 0;
    bit seen_last = 0;
    @(negedge clk);
    m_tready = 1'b1;
    for (int k = 0; k < n + 4 && !seen_last; k++) begin
      #1;
      if (m_tvalid) begin
        chk({req, " data"}, m_tdata, base + 32'(got));
        chk({req, " tlast"}, 32'(m_tlast), 32'(got == n - 1));
        if (m_tlast) seen_last = 1;
        got++;
      end
      @(negedge clk);
    end
    m_tready = 1'b0;
    chk({req, " beat count"}, 32'(got), 32'(n));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    rst_n = 1'b0; reg_valid = 1'b0; reg_write = 1'b0; reg_addr = '0; reg_wdata = '0; m_tready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(A_STS, v);  chk("R1 status", v, 32'h0);
    reg_rd(A_FREE, v); chk("R1 free", v, 32'(CAP));
    reg_rd(A_LEN, v);  chk("R1 length", v, 32'h0);
    chk("R1 tvalid", 32'(m_tvalid), 32'h0);
    chk("R1 irq", 32'(tx_irq), 32'h0);

    // vector walk: R2 R3 R5 R6 R8
    for (int i = 0; i < 5; i++) begin
      logic [31:0] base;
      logic [31:0] err_bit;
      base = 32'hC0DE_0000 + (32'(i) << 8);
      err_bit = VEC[i].mism ? S_LEN_ERR : 32'h0;
      reg_wr(A_STS, 32'hFFFF_FFFF);
      put_words(int'(VEC[i].words), base);
      reg_rd(A_FREE, v); chk("R2 free after writes", v, 32'(CAP) - 32'(VEC[i].words));
      chk("R3 no beat before commit", 32'(m_tvalid), 32'h0);
      reg_wr(A_LEN, 32'(VEC[i].bytes));
      reg_rd(A_STS, v); chk("R6 length check bit", v, err_bit);
      reg_rd(A_LEN, v); chk("R5 length readback", v, 32'(VEC[i].bytes));
      drain(int'(VEC[i].words), base, "R3 packet");
      reg_rd(A_STS, v); chk("R8 sent bit", v, err_bit | S_SENT);
      reg_rd(A_FREE, v); chk("R2 free restored", v, 32'(CAP));
    end

    // R4 backpressure
    reg_wr(A_STS, 32'hFFFF_FFFF);
    put_words(2, 32'hBEEF_0000);
    reg_wr(A_LEN, 32'd8);
    repeat (3) @(negedge clk);
    #1;
    chk("R4 tvalid held", 32'(m_tvalid), 32'h1);
    chk("R4 tdata held", m_tdata, 32'hBEEF_0000);
    chk("R4 tlast held", 32'(m_tlast), 32'h0);
    drain(2, 32'hBEEF_0000, "R4 packet");

    // R11 back to back packets
    put_words(2, 32'hA000_0000);
    reg_wr(A_LEN, 32'd8);
    put_words(3, 32'hB000_0000);
    reg_wr(A_LEN, 32'd12);
    drain(2, 32'hA000_0000, "R11 first");
    drain(3, 32'hB000_0000, "R11 second");

    // R6 commit with nothing pending
    reg_wr(A_STS, 32'hFFFF_FFFF);
    reg_wr(A_LEN, 32'd4);
    repeat (2) @(negedge clk);
    #1 chk("R6 empty commit no beat", 32'(m_tvalid), 32'h0);
    reg_rd(A_STS, v); chk("R6 empty commit flag", v, S_LEN_ERR);

    // R7 overrun
    reg_wr(A_STS, 32'hFFFF_FFFF);
    put_words(int'(CAP), 32'h7700_0000);
    reg_rd(A_FREE, v); chk("R7 free zero", v, 32'h0);
    reg_rd(A_STS, v);  chk("R7 no flag yet", v, 32'h0);
    reg_wr(A_DATA, 32'hDEAD_DEAD);
    reg_rd(A_STS, v);  chk("R7 overrun flag", v, S_OVR);
    chk("R10 irq on overrun", 32'(tx_irq), 32'h1);
    reg_wr(A_LEN, 32'(CAP * 4));
    reg_rd(A_STS, v);  chk("R7 dropped word not counted", v, S_OVR);
    drain(int'(CAP), 32'h7700_0000, "R7 full packet");

    // R9 keyed flush
    reg_wr(A_STS, 32'hFFFF_FFFF);
    put_words(3, 32'h9900_0000);
    reg_wr(A_FLUSH, 32'h0000_005A);
    reg_rd(A_FREE, v); chk("R9 wrong key ignored free", v, 32'(CAP) - 32'd3);
    reg_rd(A_STS, v);  chk("R9 wrong key ignored status", v, 32'h0);
    reg_rd(A_LEN, v);  chk("R9 wrong key ignored length", v, 32'(CAP * 4));
    reg_wr(A_FLUSH, 32'h0000_00A5);
    reg_rd(A_FREE, v); chk("R9 flush free", v, 32'(CAP));
    reg_rd(A_STS, v);  chk("R9 flush status", v, S_FLUSHED);
    reg_rd(A_LEN, v);  chk("R9 flush length", v, 32'h0);
    chk("R9 flush tvalid", 32'(m_tvalid), 32'h0);
    put_words(1, 32'h1234_5678);
    reg_wr(A_LEN, 32'd4);
    drain(1, 32'h1234_5678, "R9 partial discarded");

    // R10 write-one-to-clear
    reg_rd(A_STS, v); chk("R10 both set", v, S_FLUSHED | S_SENT);
    reg_wr(A_STS, S_SENT);
    reg_rd(A_STS, v); chk("R10 selective clear", v, S_FLUSHED);
    chk("R10 irq still high", 32'(tx_irq), 32'h1);
    reg_wr(A_STS, S_FLUSHED);
    reg_rd(A_STS, v); chk("R10 all clear", v, 32'h0);
    chk("R10 irq low", 32'(tx_irq), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule